// File: doc/BRIEF.md
# Incremental line scan-converter

This block turns a line segment, given as two signed integer endpoints, into a stream of pixel coordinates. It works the incremental way. It forms the signed deltas and takes the larger delta magnitude as the number of steps. It then divides each delta by that step count into a signed fixed-point increment. Starting from the first endpoint, it adds the increments once per emitted pixel, and each output coordinate is the running position rounded to the nearest integer.

A client pulses `start` with both endpoints while the block is idle. The block then keeps `busy` high while it works out the increments with a bit-serial divider, one pair per axis running side by side. After that it offers pixels on a valid/ready stream. A pixel is consumed on each clock where both `pix_valid` and `pix_ready` are high. One clock after the last pixel is consumed, `done` pulses for a single cycle and the block is idle again. A degenerate segment, where both endpoints are the same, skips the division and produces just one pixel.

Top module: `dda_line_raster`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `done` and `pix_valid` are all low.
- R2: With dx = x_to − x_from and dy = y_to − y_from, the step count S is |dx| when |dx| > |dy|, and |dy| otherwise. Exactly S+1 pixels are produced for each accepted `start`.
- R3: The first pixel produced is (x_from, y_from).
- R4: Pixel k (0 ≤ k ≤ S) is floor((P0 + k·I + 2^(F−1)) / 2^F) for each axis. P0 is the start coordinate times 2^F, F = COORD_W+2 fractional bits, and I = sign(d)·floor(|d|·2^F / S).
- R5: The last pixel produced is exactly (x_to, y_to).
- R6: When both endpoints coincide, exactly one pixel equal to that point is produced.
- R7: `busy` rises in the cycle after `start` is taken and stays high until the cycle in which `done` is high. A `start` pulse while `busy` is high is ignored, and the pixel stream of the line in progress is unchanged.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x` and `pix_y` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the final pixel is consumed. `busy` is low in that cycle.
- R10: Successive pixels of one line differ by at most 1 in each coordinate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line; taken only while idle |
| x_from | input | COORD_W | Signed start x |
| y_from | input | COORD_W | Signed start y |
| x_to | input | COORD_W | Signed end x |
| y_to | input | COORD_W | Signed end y |
| busy | output | 1 | Line being processed |
| done | output | 1 | One-cycle pulse after the last pixel is consumed |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer accepts the offered pixel |
| pix_x | output | COORD_W | Signed pixel x |
| pix_y | output | COORD_W | Signed pixel y |

## Verification
The properties assume that the consumer may hold `pix_ready` low for any number of cycles. They also assume that `start` can arrive at any time, including mid-line. The unit-step property assumes that endpoints are in-range signed COORD_W values, so that the fixed-point position never wraps. The stimulus keeps to these assumptions: it draws endpoints only from the signed COORD_W range, including the extreme corners. It throttles `pix_ready` with a pseudo-random pattern on some lines, and it fires a deliberate `start` in the middle of a busy line.

// File: rtl/dda_pkg.sv
package dda_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DIV,
    ST_LOAD,
    ST_EMIT
  } dda_state_e;

  localparam int AXES = 2;
endpackage

// File: rtl/dda_setup.sv
// Delta magnitudes, directions and major-axis step count from two endpoints.
module dda_setup #(
  parameter int COORD_W = 10
) (
  input  logic signed [COORD_W-1:0] ax,
  input  logic signed [COORD_W-1:0] ay,
  input  logic signed [COORD_W-1:0] bx,
  input  logic signed [COORD_W-1:0] by,
  output logic        [COORD_W-1:0] mag_x,
  output logic        [COORD_W-1:0] mag_y,
  output logic                      neg_x,
  output logic                      neg_y,
  output logic        [COORD_W-1:0] steps
);
  logic signed [COORD_W:0] dx, dy;
  logic        [COORD_W:0] ux, uy;

  assign dx = {bx[COORD_W-1], bx} - {ax[COORD_W-1], ax};
  assign dy = {by[COORD_W-1], by} - {ay[COORD_W-1], ay};

  assign neg_x = dx[COORD_W];
  assign neg_y = dy[COORD_W];

  // magnitude of a (COORD_W+1)-bit difference of in-range coordinates fits COORD_W bits
  assign ux = neg_x ? (~dx + 1'b1) : dx;
  assign uy = neg_y ? (~dy + 1'b1) : dy;
  assign mag_x = COORD_W'(ux);
  assign mag_y = COORD_W'(uy);

  assign steps = (mag_x > mag_y) ? mag_x : mag_y;
endmodule

// File: rtl/dda_div.sv
// Bit-serial restoring divider: one quotient bit per clock, NUM_W clocks per divide.
module dda_div #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 10,
  parameter int Q_W   = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [Q_W-1:0]   quo,
  output logic             fin
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] shq;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem, shq[NUM_W-1]};
  assign ge    = trial >= {1'b0, den};
  assign diff  = trial - {1'b0, den};
  assign quo   = shq[Q_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      shq <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem <= '0;
        shq <= num;
        cnt <= CNT_W'(NUM_W);
        run <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        shq <= {shq[NUM_W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dda_stepper.sv
// Fixed-point position accumulators, rounding and the pixel valid/ready stage.
module dda_stepper #(
  parameter int COORD_W = 10,
  parameter int FRAC_W  = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic signed [COORD_W-1:0]      org_x,
  input  logic signed [COORD_W-1:0]      org_y,
  input  logic signed [FRAC_W+1:0]       inc_x,
  input  logic signed [FRAC_W+1:0]       inc_y,
  input  logic        [COORD_W-1:0]      span,
  input  logic                           pix_ready,
  output logic                           pix_valid,
  output logic signed [COORD_W-1:0]      pix_x,
  output logic signed [COORD_W-1:0]      pix_y,
  output logic                           last_take
);
  import dda_pkg::*;

  localparam int POS_W = COORD_W + FRAC_W;
  localparam int INC_W = FRAC_W + 2;
  localparam logic signed [POS_W-1:0] HALF = POS_W'(1) << (FRAC_W - 1);

  logic        [COORD_W-1:0] remain;
  logic                      take;
  logic signed [COORD_W-1:0] org_a [AXES];
  logic signed [INC_W-1:0]   inc_a [AXES];
  logic signed [COORD_W-1:0] pix_a [AXES];

  assign org_a[0] = org_x;
  assign org_a[1] = org_y;
  assign inc_a[0] = inc_x;
  assign inc_a[1] = inc_y;
  assign pix_x    = pix_a[0];
  assign pix_y    = pix_a[1];

  assign take      = pix_valid && pix_ready;
  assign last_take = take && (remain == '0);

  function automatic logic signed [COORD_W-1:0] round_pos(input logic signed [POS_W-1:0] p);
    return COORD_W'((p + HALF) >>> FRAC_W);
  endfunction

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic signed [POS_W-1:0]   pos;
    logic signed [POS_W-1:0]   nxt;
    logic signed [COORD_W-1:0] pix_r;

    assign nxt      = pos + {{(POS_W-INC_W){inc_a[g][INC_W-1]}}, inc_a[g]};
    assign pix_a[g] = pix_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pos   <= '0;
        pix_r <= '0;
      end else if (load) begin
        pos   <= {org_a[g], {FRAC_W{1'b0}}};
        pix_r <= org_a[g];
      end else if (take && (remain != '0)) begin
        pos   <= nxt;
        pix_r <= round_pos(nxt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      remain    <= '0;
    end else if (load) begin
      pix_valid <= 1'b1;
      remain    <= span;
    end else if (take) begin
      if (remain == '0) pix_valid <= 1'b0;
      else              remain    <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dda_line_raster.sv
// Top: endpoint capture, sequencing of setup / divide / emit.
module dda_line_raster #(
  parameter int COORD_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [COORD_W-1:0] x_from,
  input  logic signed [COORD_W-1:0] y_from,
  input  logic signed [COORD_W-1:0] x_to,
  input  logic signed [COORD_W-1:0] y_to,
  output logic                      busy,
  output logic                      done,
  output logic                      pix_valid,
  input  logic                      pix_ready,
  output logic signed [COORD_W-1:0] pix_x,
  output logic signed [COORD_W-1:0] pix_y
);
  import dda_pkg::*;

  localparam int FRAC_W = COORD_W + 2;       // keeps end-of-line rounding error below half a pixel
  localparam int NUM_W  = COORD_W + FRAC_W;
  localparam int INC_W  = FRAC_W + 2;

  dda_state_e state;

  logic signed [COORD_W-1:0] ax_q, ay_q, bx_q, by_q;
  logic        [COORD_W-1:0] step_q;
  logic signed [INC_W-1:0]   inc_q [AXES];

  logic [COORD_W-1:0] mag_c [AXES];
  logic               neg_c [AXES];
  logic [COORD_W-1:0] step_c;
  logic [INC_W-1:0]   div_quo [AXES];
  logic [AXES-1:0]    div_fin;
  logic signed [INC_W-1:0] qmag [AXES];
  logic               div_go;
  logic               load;
  logic               last_take;

  dda_setup #(.COORD_W(COORD_W)) u_setup (
    .ax    (ax_q),
    .ay    (ay_q),
    .bx    (bx_q),
    .by    (by_q),
    .mag_x (mag_c[0]),
    .mag_y (mag_c[1]),
    .neg_x (neg_c[0]),
    .neg_y (neg_c[1]),
    .steps (step_c)
  );

  assign div_go = (state == ST_SETUP) && (step_c != '0);

  for (genvar g = 0; g < AXES; g++) begin : g_div
    dda_div #(.NUM_W(NUM_W), .DEN_W(COORD_W), .Q_W(INC_W)) u_div (
      .clk (clk),
      .rst (rst),
      .go  (div_go),
      .num ({mag_c[g], {FRAC_W{1'b0}}}),
      .den (step_c),
      .quo (div_quo[g]),
      .fin (div_fin[g])
    );
    assign qmag[g] = signed'(div_quo[g]);
  end

  assign load = (state == ST_LOAD);
  assign busy = (state != ST_IDLE);

  dda_stepper #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_step (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .org_x     (ax_q),
    .org_y     (ay_q),
    .inc_x     (inc_q[0]),
    .inc_y     (inc_q[1]),
    .span      (step_q),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .last_take (last_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      ax_q   <= '0;
      ay_q   <= '0;
      bx_q   <= '0;
      by_q   <= '0;
      step_q <= '0;
      for (int a = 0; a < AXES; a++) inc_q[a] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ax_q  <= x_from;
            ay_q  <= y_from;
            bx_q  <= x_to;
            by_q  <= y_to;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          step_q <= step_c;
          for (int a = 0; a < AXES; a++) inc_q[a] <= '0;
          state  <= (step_c == '0) ? ST_LOAD : ST_DIV;
        end
        ST_DIV: begin
          if (&div_fin) begin
            for (int a = 0; a < AXES; a++)
              inc_q[a] <= neg_c[a] ? -qmag[a] : qmag[a];
            state <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_EMIT;
        ST_EMIT: begin
          if (last_take) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dda_line_raster_chk.sv
module dda_line_raster_chk #(
  parameter int COORD_W = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      busy,
  input logic                      done,
  input logic                      pix_valid,
  input logic                      pix_ready,
  input logic signed [COORD_W-1:0] pix_x,
  input logic signed [COORD_W-1:0] pix_y
);
  logic signed [COORD_W-1:0] prev_x, prev_y;
  logic                      have_prev;
  logic signed [COORD_W:0]   ddx, ddy;

  assign ddx = {pix_x[COORD_W-1], pix_x} - {prev_x[COORD_W-1], prev_x};
  assign ddy = {pix_y[COORD_W-1], pix_y} - {prev_y[COORD_W-1], prev_y};

  always_ff @(posedge clk) begin
    if (rst || done) begin
      have_prev <= 1'b0;
      prev_x    <= '0;
      prev_y    <= '0;
    end else if (pix_valid && pix_ready) begin
      have_prev <= 1'b1;
      prev_x    <= pix_x;
      prev_y    <= pix_y;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !pix_valid));

  p_valid_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> busy);

  p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !pix_valid));

  p_unit_move_r10: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_ready && have_prev) |->
      (ddx >= -1 && ddx <= 1 && ddy >= -1 && ddy <= 1));
endmodule

bind dda_line_raster dda_line_raster_chk #(.COORD_W(COORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_x     (pix_x),
  .pix_y     (pix_y)
);

// File: tb/dda_line_raster_test.sv
module dda_line_raster_test;
  localparam int CW       = 10;
  localparam int FW       = CW + 2;
  localparam int CLK_NS   = 10;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic [3:0]    tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [CW-1:0] x_from = '0, y_from = '0, x_to = '0, y_to = '0;
  logic pix_ready = 1'b0;
  logic busy, done, pix_valid;
  logic signed [CW-1:0] pix_x, pix_y;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  item_t exp_q[$];
  bit    throttle = 1'b0;
  logic [15:0] rlfsr = 16'hACE1;
  logic [15:0] elfsr = 16'h5A3C;
  logic        stall_seen = 1'b0;
  logic signed [CW-1:0] stall_x, stall_y;

  dda_line_raster #(.COORD_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start),
    .x_from(x_from), .y_from(y_from), .x_to(x_to), .y_to(y_to),
    .busy(busy), .done(done), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected pixel list from the written rule (R2..R6)
  task automatic push_model(input int x0, input int y0, input int x1, input int y1);
    longint dx, dy, mx, my, st, ix, iy, px, py;
    item_t it;
    dx = x1 - x0; dy = y1 - y0;
    mx = (dx < 0) ? -dx : dx;
    my = (dy < 0) ? -dy : dy;
    st = (mx > my) ? mx : my;
    if (st == 0) begin
      it.x = CW'(x0); it.y = CW'(y0); it.tag = 4'd6;   // R6
      exp_q.push_back(it);
      return;
    end
    ix = (mx <<< FW) / st; if (dx < 0) ix = -ix;
    iy = (my <<< FW) / st; if (dy < 0) iy = -iy;
    for (longint k = 0; k <= st; k++) begin
      px = ((longint'(x0) <<< FW) + k * ix + (64'sd1 <<< (FW-1))) >>> FW;
      py = ((longint'(y0) <<< FW) + k * iy + (64'sd1 <<< (FW-1))) >>> FW;
      it.x = CW'(px); it.y = CW'(py);
      // first pixel R3, last pixel R5, interior R4
      it.tag = (k == 0) ? 4'd3 : ((k == st) ? 4'd5 : 4'd4);
      exp_q.push_back(it);
    end
  endtask

  // Monitor / scoreboard: ready chosen first, then the pixel taken at the next edge is compared
  always @(negedge clk) begin
    if (!rst) begin
      rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
      if (stall_seen) begin
        check(pix_valid === 1'b1, "R8", "valid held in stall", longint'(pix_valid), 1);
        check(pix_x === stall_x && pix_y === stall_y, "R8", "pixel held in stall x",
              longint'(pix_x), longint'(stall_x));
      end
      pix_ready = throttle ? (rlfsr[0] | rlfsr[3]) : 1'b1;
      stall_seen = pix_valid && !pix_ready;
      stall_x = pix_x;
      stall_y = pix_y;
      if (pix_valid && pix_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected extra pixel count", 1, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(pix_x === signed'(e.x), $sformatf("R%0d", e.tag), "pixel x",
                longint'(pix_x), longint'(signed'(e.x)));
          check(pix_y === signed'(e.y), $sformatf("R%0d", e.tag), "pixel y",
                longint'(pix_y), longint'(signed'(e.y)));
        end
      end
    end
  end

  task automatic run_line(input int x0, input int y0, input int x1, input int y1, input bit poke);
    int waited;
    push_model(x0, y0, x1, y1);
    @(negedge clk);
    x_from = CW'(x0); y_from = CW'(y0); x_to = CW'(x1); y_to = CW'(y1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7", "busy after start", longint'(busy), 1);
    if (poke) begin
      // R7: second start mid-line with different endpoints must be ignored
      @(negedge clk);
      x_from = -CW'(3); y_from = CW'(77); x_to = CW'(200); y_to = -CW'(150);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R7", "busy during ignored start", longint'(busy), 1);
    end
    waited = 0;
    while (done !== 1'b1 && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (done !== 1'b1)
        check(busy === 1'b1, "R7", "busy until done", longint'(busy), 1);
    end
    check(done === 1'b1, "R9", "done seen", longint'(done), 1);
    check(exp_q.size() == 0, "R2", "pixels left unproduced", exp_q.size(), 0);
    check(busy === 1'b0 && pix_valid === 1'b0, "R9", "idle with done", longint'(busy), 0);
    exp_q.delete();
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle only", longint'(done), 0);
  endtask

  function automatic int rnd_coord();
    elfsr = {elfsr[14:0], elfsr[15] ^ elfsr[13] ^ elfsr[12] ^ elfsr[10]};
    elfsr = {elfsr[14:0], elfsr[15] ^ elfsr[13] ^ elfsr[12] ^ elfsr[10]};
    return int'(signed'(elfsr[CW-1:0]));
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL R9 watchdog: cycles %0d expected completion before %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && pix_valid === 1'b0, "R1", "outputs in reset",
          longint'({busy, done, pix_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && pix_valid === 1'b0, "R1", "outputs after reset",
          longint'({busy, done, pix_valid}), 0);

    throttle = 1'b0;
    run_line(0, 0, 10, 0, 1'b0);        // horizontal, R2/R3/R5
    run_line(5, -4, 5, 20, 1'b0);       // vertical
    run_line(-7, -7, 9, 9, 1'b0);       // diagonal
    run_line(12, 3, -1, 40, 1'b0);      // steep, x falling (R4 rounding)
    run_line(30, 10, -20, 1, 1'b0);     // shallow, both falling
    run_line(100, -50, 100, -50, 1'b0); // coincident, R6
    run_line(0, 0, 7, 3, 1'b1);         // ignored start mid-line, R7

    throttle = 1'b1;                    // back-pressure, R8
    run_line(3, 1, 20, 9, 1'b0);
    run_line(-512, -512, 511, 511, 1'b0);
    run_line(511, -512, -512, 510, 1'b0);
    run_line(-512, 0, -512, 0, 1'b0);
    run_line(-20, 5, 15, -11, 1'b1);
    for (int i = 0; i < 12; i++) begin
      int a, b, c, d;
      a = rnd_coord(); b = rnd_coord(); c = rnd_coord(); d = rnd_coord();
      throttle = i[0];
      run_line(a, b, c, d, 1'b0);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule